// File: doc/BRIEF.md
# Clock Update Cycle Sequencer

This block paces the once-per-second advance of a real-time clock and publishes a busy status for software. It counts enable pulses from a 32.768 kHz reference in a power-of-two prescaler. A fixed number of ticks before the prescaler rolls over, it raises a busy flag. At the rollover it emits a one-cycle update strobe that tells the calendar counters to advance. It keeps the flag high for a fixed update window after that, then drops it and emits a one-cycle update-ended pulse.

Software that polls the busy flag through the read port knows that the time fields are safe to read for at least the lead time after it sees the flag low. A set-mode input lets software load new time values: no cycle starts while it is high, and a cycle already running is abandoned. A divider-hold input clears the prescaler and keeps the sequencer idle, so the first second after release is a full one.

Top module: `upd_cycle_seq`

## Requirements
- R1: After a synchronous active-low reset, the busy flag, update strobe, update-ended pulse and read data are all zero, even if reset is applied in the middle of a cycle.
- R2: The busy flag rises exactly LEAD_TICKS reference ticks before the update strobe, and the strobe is high for one clock cycle while busy is high.
- R3: The busy flag stays high for WIN_TICKS reference ticks after the strobe. It falls in the same cycle in which the one-cycle update-ended pulse is high.
- R4: Update strobes recur every 2^PRESCALE_W reference ticks. The prescaler advances only on clock cycles where the tick enable is high.
- R5: While set mode is high, no cycle starts, and neither busy nor the strobe appears. Cycles resume at the next rollover after set mode falls.
- R6: Set mode asserted while a cycle is running, during the lead or the window, clears busy on the next cycle. That cycle then produces no further strobe and no update-ended pulse.
- R7: While divider hold is high, the prescaler is held at zero, busy is low and no cycle starts, and a running cycle is cleared. After release, busy rises after 2^PRESCALE_W − LEAD_TICKS ticks.
- R8: A read request loads the read data on the next cycle with the busy flag in bit 7 and zeros in bits 6..0. Without a request the read data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle pulse per reference clock period |
| set_mode | input | 1 | High while software loads the time; inhibits and aborts update cycles |
| div_hold | input | 1 | Holds the prescaler at zero and the sequencer idle |
| rd_en | input | 1 | Read request for the status byte |
| rd_data | output | 8 | Status byte captured on a read; bit 7 is busy |
| busy | output | 1 | Update-in-progress flag |
| upd_stb | output | 1 | One-cycle pulse: advance the time counters |
| upd_done | output | 1 | One-cycle pulse at the end of the update window |

## Verification
The main timing is driven with tick enables spaced 1, 2, 3 and 5 clock cycles apart. In each case the bench measures the lead, the window and the strobe-to-strobe period in clock cycles. This separates counting on ticks from counting on clocks, and an off-by-one at either boundary shows up as a mismatch that grows with the spacing. Directed runs then use ticks on every cycle and check the following:
- set mode held from reset;
- set mode pulsed in the lead and in the window;
- divider hold, both as a long hold and as a mid-cycle pulse;
- reads while idle and while busy;
- reset during a busy cycle.

Each of these distinguishes an abort from a cycle that is allowed to finish.

// File: rtl/upd_seq_pkg.sv
// Package: shared types for the update cycle sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package upd_seq_pkg;
    // Phase of the update cycle
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_WIN  = 2'd2
    } phase_t;

    // Bit of the status byte that carries the busy flag
    localparam int STATUS_BUSY_BIT = 7;
    localparam int STATUS_W        = 8;
endpackage

// File: rtl/upd_seq_prescaler.sv
// Module: one-second prescaler counting reference ticks.
// Produces a hit LEAD ticks before rollover and a hit on the rollover tick.
// Assumes: LEAD < 2**W; tick_en is a one-cycle pulse per reference period.
module upd_seq_prescaler #(
    parameter int W    = 15,
    parameter int LEAD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic div_hold,
    output logic lead_hit,
    output logic wrap_hit
);
    localparam logic [W-1:0] LAST      = {W{1'b1}};
    localparam logic [W-1:0] LEAD_MARK = LAST - W'(LEAD);

    logic [W-1:0] cnt;
    logic         adv;

    assign adv = tick_en && !div_hold;

    // Advance on each accepted tick; divider hold clears the count
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (div_hold) cnt <= '0;
        else if (tick_en)  cnt <= cnt + 1'b1;
    end

    // Events taken from the count value seen before the tick lands
    always_comb begin
        lead_hit = adv && (cnt == LEAD_MARK);
        wrap_hit = adv && (cnt == LAST);
    end
endmodule

// File: rtl/upd_seq_phase_fsm.sv
// Module: sequences lead, update strobe, window and end pulse.
// Assumes: hits come from upd_seq_prescaler and are already gated by div_hold.
module upd_seq_phase_fsm
    import upd_seq_pkg::*;
#(
    parameter int WIN = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic set_mode,
    input  logic div_hold,
    input  logic lead_hit,
    input  logic wrap_hit,
    output logic busy,
    output logic upd_stb,
    output logic upd_done
);
    localparam int             WW       = $clog2(WIN + 1);
    localparam logic [WW-1:0]  WIN_LAST = WW'(WIN - 1);

    phase_t        phase;
    logic [WW-1:0] win_cnt;
    logic          stop;

    assign stop = set_mode || div_hold;

    // Phase transitions, window count and one-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            win_cnt  <= '0;
            upd_stb  <= 1'b0;
            upd_done <= 1'b0;
        end else begin
            upd_stb  <= 1'b0;
            upd_done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (lead_hit && !stop) phase <= PH_LEAD;
                end
                PH_LEAD: begin
                    if (stop) begin
                        phase <= PH_IDLE;
                    end else if (wrap_hit) begin
                        phase   <= PH_WIN;
                        win_cnt <= '0;
                        upd_stb <= 1'b1;
                    end
                end
                PH_WIN: begin
                    if (stop) begin
                        phase <= PH_IDLE;
                    end else if (tick_en) begin
                        if (win_cnt == WIN_LAST) begin
                            phase    <= PH_IDLE;
                            upd_done <= 1'b1;
                        end else begin
                            win_cnt <= win_cnt + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Busy covers lead and window
    assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/upd_seq_status_port.sv
// Module: status byte read port; captures busy on a read request.
// Assumes: reads are single-cycle requests; data holds between reads.
module upd_seq_status_port
    import upd_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic                busy,
    output logic [STATUS_W-1:0] rd_data
);
    // Capture the status byte on each read request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data                  <= '0;
            rd_data[STATUS_BUSY_BIT] <= busy;
        end
    end
endmodule

// File: rtl/upd_cycle_seq.sv
// Module: top of the clock update cycle sequencer.
// Raises busy LEAD_TICKS ticks before each one-second update, strobes the
// update, holds busy WIN_TICKS more ticks, then pulses update-ended.
// Assumes: tick_en is a one-cycle pulse at the reference rate.
module upd_cycle_seq #(
    parameter int PRESCALE_W = 15,
    parameter int LEAD_TICKS = 8,
    parameter int WIN_TICKS  = 65
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       set_mode,
    input  logic       div_hold,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic       upd_stb,
    output logic       upd_done
);
    logic lead_hit;
    logic wrap_hit;

    upd_seq_prescaler #(
        .W    (PRESCALE_W),
        .LEAD (LEAD_TICKS)
    ) presc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .div_hold (div_hold),
        .lead_hit (lead_hit),
        .wrap_hit (wrap_hit)
    );

    upd_seq_phase_fsm #(
        .WIN (WIN_TICKS)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .set_mode (set_mode),
        .div_hold (div_hold),
        .lead_hit (lead_hit),
        .wrap_hit (wrap_hit),
        .busy     (busy),
        .upd_stb  (upd_stb),
        .upd_done (upd_done)
    );

    upd_seq_status_port stat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .busy    (busy),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/upd_cycle_seq_chk.sv
// Module: property checker for upd_cycle_seq, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module upd_cycle_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       set_mode,
    input logic       div_hold,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic       upd_stb,
    input logic       upd_done
);
    a_r2_stb_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |-> busy);

    a_r2_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !upd_stb);

    a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> (!busy && $past(busy)));

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);

    a_r5_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!set_mode && !div_hold));

    a_r6_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode || div_hold) |=> !busy);

    a_r8_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data == {$past(busy), 7'b0}));

    a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind upd_cycle_seq upd_cycle_seq_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mode (set_mode),
    .div_hold (div_hold),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .busy     (busy),
    .upd_stb  (upd_stb),
    .upd_done (upd_done)
);

// File: tb/upd_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module upd_cycle_seq_tb_top;
    localparam int PW  = 8;
    localparam int LD  = 8;
    localparam int WN  = 65;
    localparam int PER = 1 << PW;

    typedef struct packed {
        int div;
        int lead_cyc;
        int win_cyc;
        int per_cyc;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VECS [NVEC] = '{
        '{1, LD * 1, WN * 1, PER * 1},
        '{2, LD * 2, WN * 2, PER * 2},
        '{3, LD * 3, WN * 3, PER * 3},
        '{5, LD * 5, WN * 5, PER * 5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       set_mode = 1'b0;
    logic       div_hold = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       busy;
    logic       upd_stb;
    logic       upd_done;

    always #2 clk = ~clk;

    upd_cycle_seq #(
        .PRESCALE_W (PW),
        .LEAD_TICKS (LD),
        .WIN_TICKS  (WN)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .set_mode (set_mode),
        .div_hold (div_hold),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .busy     (busy),
        .upd_stb  (upd_stb),
        .upd_done (upd_done)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int tick_div = 1;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Tick generator: one pulse every tick_div cycles
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
            tick_en = (ph == 0);
        end
    end

    // Event monitor: timestamps of busy edges, strobes and end pulses
    int n_rise, n_fall, n_stb, n_done;
    int t_rise [4];
    int t_fall [4];
    int t_stb  [4];
    int t_done [4];
    logic busy_q = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            n_rise = 0; n_fall = 0; n_stb = 0; n_done = 0;
        end else begin
            if (busy && !busy_q) begin
                if (n_rise < 4) t_rise[n_rise] = cyc;
                n_rise++;
            end
            if (!busy && busy_q) begin
                if (n_fall < 4) t_fall[n_fall] = cyc;
                n_fall++;
            end
            if (upd_stb) begin
                if (n_stb < 4) t_stb[n_stb] = cyc;
                n_stb++;
            end
            if (upd_done) begin
                if (n_done < 4) t_done[n_done] = cyc;
                n_done++;
            end
        end
        busy_q = busy;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int div, input bit sm);
        @(negedge clk);
        rst_n = 1'b0; set_mode = 1'b0; div_hold = 1'b0; rd_en = 1'b0;
        tick_div = div;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        set_mode = sm;
    endtask

    task automatic wait_done(input int k, input int limit);
        for (int i = 0; i < limit && n_done < k; i++) @(negedge clk);
    endtask

    task automatic wait_rise(input int k, input int limit);
        for (int i = 0; i < limit && n_rise < k; i++) @(negedge clk);
    endtask

    task automatic wait_stb(input int k, input int limit);
        for (int i = 0; i < limit && n_stb < k; i++) @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        int c0;
        // Vector table: lead, window and period at several tick spacings
        for (int v = 0; v < NVEC; v++) begin
            do_reset(VECS[v].div, 1'b0);
            wait_done(2, 3 * VECS[v].per_cyc + 500);
            chk(n_done >= 2, "R4 two updates seen", n_done, 2);
            chk(t_stb[0] - t_rise[0] == VECS[v].lead_cyc, "R2 lead cycles",
                t_stb[0] - t_rise[0], VECS[v].lead_cyc);
            chk(t_done[0] - t_stb[0] == VECS[v].win_cyc, "R3 window cycles",
                t_done[0] - t_stb[0], VECS[v].win_cyc);
            chk(t_fall[0] == t_done[0], "R3 busy falls with done", t_fall[0], t_done[0]);
            chk(t_stb[1] - t_stb[0] == VECS[v].per_cyc, "R4 period cycles",
                t_stb[1] - t_stb[0], VECS[v].per_cyc);
            chk(n_stb == n_done, "R2 one strobe per cycle", n_stb, n_done);
        end

        // R1: reset in the middle of a busy cycle
        do_reset(1, 1'b0);
        wait_rise(1, PER + 50);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data == 8'h80, "R8 read while busy", rd_data, 8'h80);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(upd_stb == 1'b0 && upd_done == 1'b0, "R1 pulses after reset",
            {upd_stb, upd_done}, 0);
        chk(rd_data == 8'h00, "R1 read data after reset", rd_data, 0);

        // R8: read while idle, then hold without request
        do_reset(1, 1'b0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data == 8'h00, "R8 read while idle", rd_data, 0);
        wait_rise(1, PER + 50);
        @(negedge clk);
        chk(rd_data == 8'h00, "R8 hold without request", rd_data, 0);

        // R5: set mode held from reset inhibits cycles
        do_reset(1, 1'b1);
        repeat (2 * PER + 10) @(negedge clk);
        chk(n_rise == 0, "R5 no busy in set mode", n_rise, 0);
        chk(n_stb == 0, "R5 no strobe in set mode", n_stb, 0);
        set_mode = 1'b0;
        wait_done(1, 2 * PER + 100);
        chk(n_done == 1, "R5 cycles resume", n_done, 1);

        // R6: abort during lead
        do_reset(1, 1'b0);
        wait_rise(1, PER + 50);
        @(negedge clk);
        set_mode = 1'b1;
        @(negedge clk);
        set_mode = 1'b0;
        chk(busy == 1'b0, "R6 lead abort clears busy", busy, 0);
        repeat (LD + WN + 10) @(negedge clk);
        chk(n_stb == 0, "R6 no strobe after lead abort", n_stb, 0);
        chk(n_done == 0, "R6 no done after lead abort", n_done, 0);

        // R6: abort during window
        do_reset(1, 1'b0);
        wait_stb(1, PER + 50);
        repeat (5) @(negedge clk);
        set_mode = 1'b1;
        @(negedge clk);
        set_mode = 1'b0;
        chk(busy == 1'b0, "R6 window abort clears busy", busy, 0);
        repeat (WN + 10) @(negedge clk);
        chk(n_done == 0, "R6 no done after window abort", n_done, 0);

        // R7: divider hold keeps idle; full second after release
        do_reset(1, 1'b0);
        div_hold = 1'b1;
        repeat (PER + 20) @(negedge clk);
        chk(n_rise == 0, "R7 no busy during hold", n_rise, 0);
        div_hold = 1'b0;
        c0 = cyc;
        wait_rise(1, PER + 50);
        chk(t_rise[0] - c0 == PER - LD, "R7 first rise after release",
            t_rise[0] - c0, PER - LD);
        @(negedge clk);
        div_hold = 1'b1;
        @(negedge clk);
        div_hold = 1'b0;
        chk(busy == 1'b0, "R7 hold clears running cycle", busy, 0);
        repeat (LD + WN + 10) @(negedge clk);
        chk(n_stb == 0, "R7 no strobe after hold abort", n_stb, 0);

        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end
endmodule